// File: doc/BRIEF.md
# Interrupt-Paced Register Write Sequencer

A small command engine that replays a short list of register operations against a slave register file that is slow to accept writes. Software-side logic first pushes entries into the engine. Each entry is a write (address plus data), a wait on the random-key generator, or a no-operation. A start pulse then runs the list. Each step is gated by a completion flag from the target. A write stalls until the slave reports write-complete. A key wait stalls until the generator reports valid or error.

The engine enables the matching completion interrupt only while it waits on that completion. A run ends in one of four ways: the list is exhausted, the slave flags a write error, the key generator flags an error, or a write never completes within a bounded number of cycles. Each end is reported as a 2-bit result with a one-cycle done pulse. The list is emptied as the engine returns to loading, so every run starts from a fresh list.

Top module: `paced_write_seq`

## Requirements
- R1: The list holds at most DEPTH (default 12) entries. A push made while it is full is dropped and sets `overflow`. `overflow` and the list are both cleared in the cycle after done.
- R2: Entry kind code 1 is a write and code 2 is a random-key wait. Codes 0 and 3 are no-operations: they issue no write and advance to the next entry.
- R3: `status` encodes loading=0, ready=1, waiting-write-complete=2, waiting-key=3, done=4. Done lasts exactly one cycle, with `done` high in that cycle only, and is followed by loading.
- R4: A write entry produces a single-cycle `wr_en` with its address and data. `wc_irq_en` rises together with `wr_en` and stays high exactly while the engine waits on that write.
- R5: When `wc_flag` is seen together with `wr_err_flag`, the run ends with result 1 and the remaining entries are skipped. When `wc_flag` is seen alone, the engine advances to the next entry.
- R6: During a key wait `rk_irq_en` is high. When `rk_err` is seen (it wins over `rk_valid`), the run ends with result 2. When `rk_valid` is seen alone, the engine advances.
- R7: When the entry pointer reaches the entry count, the run ends with result 0. An empty list shows done two cycles after the start pulse.
- R8: Completion flags that arrive outside their matching wait state are ignored, and so are pushes made outside loading.
- R9: A start pulse in loading raises `busy` from the next cycle until done. `busy` is low in loading and in done.
- R10: A write with no `wc_flag` for TIMEOUT (default 4096) cycles after `wr_en` ends the run with result 1.
- R11: Entries execute in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Append one entry (loading only) |
| push_kind | input | 2 | Entry kind code |
| push_addr | input | AW | Target register address |
| push_data | input | DW | Write value |
| start | input | 1 | Begin running the list |
| wr_en | output | 1 | Write strobe to slave |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wc_irq_en | output | 1 | Write-complete interrupt enable |
| wc_flag | input | 1 | Slave write-complete |
| wr_err_flag | input | 1 | Slave write-error |
| rk_irq_en | output | 1 | Key-generator interrupt enable |
| rk_valid | input | 1 | Key generator reports valid |
| rk_err | input | 1 | Key generator reports error |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 write error, 2 key failure |
| overflow | output | 1 | A push was dropped on a full list |
| status | output | 3 | Engine state code |

## Verification
The bench sweeps every list length from zero to full, with varied slave latency. It checks the exact write order, so a design that loses an entry at the end or reorders entries is caught. Errors are injected at every write position and on key waits, including valid and error arriving together; a design that advanced past an error would show extra writes or a wrong result code. Stray flags and pushes are sent during a key wait, where a design without state gating would complete early or grow its list. The thirteenth push and the exact timeout cycle are also probed, where an off-by-one would accept one entry too many or end the run a cycle early or late.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_READY = 3'd1,
    ST_PWC   = 3'd2,
    ST_PRK   = 3'd3,
    ST_DONE  = 3'd4
  } st_e;

  localparam logic [1:0] KIND_WRITE   = 2'd1;
  localparam logic [1:0] KIND_WAITKEY = 2'd2;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_WERR  = 2'd1;
  localparam logic [1:0] RES_KFAIL = 2'd2;

  function automatic logic list_full(int unsigned cnt, int unsigned depth);
    return cnt >= depth;
  endfunction

  function automatic logic list_end(int unsigned ptr, int unsigned cnt);
    return ptr >= cnt;
  endfunction

  function automatic logic limit_hit(int unsigned cnt, int unsigned lim);
    return cnt == lim - 1;
  endfunction
endpackage

// File: rtl/pws_list.sv
module pws_list #(
  parameter int DEPTH = 12,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          clear,
  input  logic          push_valid,
  input  logic [1:0]    push_kind,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [CW-1:0] rd_idx,
  output logic [CW-1:0] count,
  output logic [1:0]    rd_kind,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          overflow
);
  import pws_pkg::*;

  logic [1:0]    kind_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];

  wire full_w   = list_full(32'(count), DEPTH);
  wire accept_w = load_en && push_valid && !full_w;
  wire drop_w   = load_en && push_valid && full_w;
  wire idx_ok_w = 32'(rd_idx) < DEPTH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (accept_w) count <= count + 1'b1;
      if (drop_w) overflow <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          kind_q[g] <= 2'd0;
          addr_q[g] <= '0;
          data_q[g] <= '0;
        end else if (accept_w && 32'(count) == g) begin
          kind_q[g] <= push_kind;
          addr_q[g] <= push_addr;
          data_q[g] <= push_data;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_kind = 2'd0;
    rd_addr = '0;
    rd_data = '0;
    if (idx_ok_w) begin
      rd_kind = kind_q[rd_idx];
      rd_addr = addr_q[rd_idx];
      rd_data = data_q[rd_idx];
    end
  end

  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && push_valid && 32'(count) == DEPTH) |=> (overflow && 32'(count) == DEPTH));
  p_no_push_outside_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !clear) |=> $stable(count));
endmodule

// File: rtl/pws_timer.sv
module pws_timer #(
  parameter int LIMIT = 4096,
  localparam int TW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  import pws_pkg::*;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expire)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && limit_hit(32'(cnt_q), LIMIT);

  p_expire_only_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> run);
endmodule

// File: rtl/paced_write_seq.sv
module paced_write_seq #(
  parameter int DEPTH   = 12,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int TIMEOUT = 4096,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [1:0]    push_kind,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          start,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wc_irq_en,
  input  logic          wc_flag,
  input  logic          wr_err_flag,
  output logic          rk_irq_en,
  input  logic          rk_valid,
  input  logic          rk_err,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          overflow,
  output logic [2:0]    status
);
  import pws_pkg::*;

  st_e           st_q;
  logic [CW-1:0] ptr_q;
  logic [CW-1:0] count_w;
  logic [1:0]    kind_w;
  logic [AW-1:0] eaddr_w;
  logic [DW-1:0] edata_w;
  logic          expire_w;

  // Named internal events, one per way a wait can end.
  wire ev_list_end = (st_q == ST_READY) && list_end(32'(ptr_q), 32'(count_w));
  wire ev_wr_ok    = (st_q == ST_PWC) && wc_flag && !wr_err_flag;
  wire ev_wr_err   = (st_q == ST_PWC) && wc_flag && wr_err_flag;
  wire ev_timeout  = (st_q == ST_PWC) && expire_w && !wc_flag;
  wire ev_rk_err   = (st_q == ST_PRK) && rk_err;
  wire ev_rk_ok    = (st_q == ST_PRK) && rk_valid && !rk_err;

  pws_list #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) list_i (
    .clk, .rst_n,
    .load_en   (st_q == ST_LOAD),
    .clear     (st_q == ST_DONE),
    .push_valid, .push_kind, .push_addr, .push_data,
    .rd_idx    (ptr_q),
    .count     (count_w),
    .rd_kind   (kind_w),
    .rd_addr   (eaddr_w),
    .rd_data   (edata_w),
    .overflow
  );

  pws_timer #(.LIMIT(TIMEOUT)) timer_i (
    .clk, .rst_n,
    .run    (st_q == ST_PWC),
    .expire (expire_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_LOAD;
      ptr_q     <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wc_irq_en <= 1'b0;
      rk_irq_en <= 1'b0;
      result    <= RES_OK;
    end else begin
      wr_en <= 1'b0;
      unique case (st_q)
        ST_LOAD: if (start) begin
          st_q  <= ST_READY;
          ptr_q <= '0;
        end
        ST_READY: begin
          if (ev_list_end) begin
            result <= RES_OK;
            st_q   <= ST_DONE;
          end else if (kind_w == KIND_WRITE) begin
            wr_en     <= 1'b1;
            wr_addr   <= eaddr_w;
            wr_data   <= edata_w;
            wc_irq_en <= 1'b1;
            st_q      <= ST_PWC;
          end else if (kind_w == KIND_WAITKEY) begin
            rk_irq_en <= 1'b1;
            st_q      <= ST_PRK;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_PWC: begin
          if (ev_wr_err || ev_timeout) begin
            wc_irq_en <= 1'b0;
            result    <= RES_WERR;
            st_q      <= ST_DONE;
          end else if (ev_wr_ok) begin
            wc_irq_en <= 1'b0;
            ptr_q     <= ptr_q + 1'b1;
            st_q      <= ST_READY;
          end
        end
        ST_PRK: begin
          if (ev_rk_err) begin
            rk_irq_en <= 1'b0;
            result    <= RES_KFAIL;
            st_q      <= ST_DONE;
          end else if (ev_rk_ok) begin
            rk_irq_en <= 1'b0;
            ptr_q     <= ptr_q + 1'b1;
            st_q      <= ST_READY;
          end
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  assign busy   = (st_q == ST_READY) || (st_q == ST_PWC) || (st_q == ST_PRK);
  assign done   = (st_q == ST_DONE);
  assign status = st_q;

  p_wc_en_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wc_irq_en |-> (st_q == ST_PWC));
  p_wr_with_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wc_irq_en);
  p_one_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wc_irq_en, rk_irq_en}));
  p_wr_err_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_err |=> (done && result == RES_WERR));
  p_rk_en_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rk_irq_en |-> (st_q == ST_PRK));
  p_rk_err_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rk_err |=> (done && result == RES_KFAIL));
  p_end_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_list_end |=> (done && result == RES_OK));
  p_ignore_stray_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRK && !rk_err && !rk_valid) |=> (st_q == ST_PRK && $stable(ptr_q)));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && status == 3'd0));
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (done && result == RES_WERR));
endmodule

// File: tb/paced_write_seq_tb.sv
module paced_write_seq_tb_top;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 12;
  localparam int TMO = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, start = 0;
  logic [1:0] push_kind = 0;
  logic [AW-1:0] push_addr = 0;
  logic [DW-1:0] push_data = 0;
  logic wr_en, wc_irq_en, rk_irq_en, busy, done, overflow;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0] result;
  logic [2:0] status;
  logic wc_m = 0, we_m = 0, rkv_m = 0, rke_m = 0;
  logic wc_x = 0, we_x = 0, rkv_x = 0, rke_x = 0;
  wire wc_flag = wc_m | wc_x;
  wire wr_err_flag = we_m | we_x;
  wire rk_valid = rkv_m | rkv_x;
  wire rk_err = rke_m | rke_x;

  int checks = 0, fails = 0;
  int lat = 1, err_at = -1, wr_mute = 0, wc_cnt = 0, last_idx = 0;
  int rk_lat = 2, rk_mode = 0, rk_mute = 0, rk_cnt = 0, rk_armed = 0;
  int log_n = 0;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];

  always #(PERIOD/2) clk = ~clk;

  paced_write_seq #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TIMEOUT(TMO)) dut_i (
    .clk, .rst_n, .push_valid, .push_kind, .push_addr, .push_data, .start,
    .wr_en, .wr_addr, .wr_data, .wc_irq_en, .wc_flag, .wr_err_flag,
    .rk_irq_en, .rk_valid, .rk_err, .busy, .done, .result, .overflow, .status);

  // Slave register file and key generator models.
  always @(negedge clk) begin
    wc_m = 0; we_m = 0; rkv_m = 0; rke_m = 0;
    if (wc_cnt > 0) begin
      wc_cnt--;
      if (wc_cnt == 0) begin wc_m = 1; we_m = (last_idx == err_at); end
    end
    if (wr_en && rst_n) begin
      if (log_n < 64) begin log_a[log_n] = wr_addr; log_d[log_n] = wr_data; end
      last_idx = log_n; log_n++;
      if (wr_mute == 0) wc_cnt = lat;
    end
    if (!rk_irq_en) rk_armed = 0;
    else if (rk_armed == 0) begin rk_armed = 1; rk_cnt = rk_lat; end
    else if (rk_cnt > 0) begin
      rk_cnt--;
      if (rk_cnt == 0 && rk_mute == 0) begin
        rkv_m = (rk_mode != 1); rke_m = (rk_mode != 0);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input int a, input int d);
    @(negedge clk);
    push_valid = 1; push_kind = k; push_addr = AW'(a); push_data = DW'(d);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output int res, output int cyc);
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    res = result;
  endtask

  function automatic int fdat(int n, int i);
    return (n * 40 + i * 7 + 3) % 65536;
  endfunction

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int res, cyc;
    repeat (3) @(negedge clk);
    // Reset state (R3, R9)
    chk(status == 0 && !busy && !done && !wr_en && !wc_irq_en && !rk_irq_en && result == 0 && !overflow,
        "R3 reset state", status, 0);
    rst_n = 1;
    @(negedge clk);

    // Stray flags in loading are ignored (R8)
    wc_x = 1; we_x = 1; rkv_x = 1; rke_x = 1;
    @(negedge clk);
    wc_x = 0; we_x = 0; rkv_x = 0; rke_x = 0;
    @(negedge clk);
    chk(status == 0 && !done, "R8 flags in loading ignored", status, 0);

    // Empty list: done two cycles after start (R7, R9, R3)
    go();
    chk(busy == 1 && status == 1, "R9 busy after start", busy, 1);
    @(negedge clk);
    chk(done == 1 && result == 0, "R7 empty list done", {done, result}, 4);
    chk(status == 4 && !busy, "R3 done code", status, 4);
    @(negedge clk);
    chk(done == 0 && status == 0, "R3 single-cycle done", done, 0);

    // Sweep of list lengths with varied latency (R2, R4, R7, R11)
    for (int n = 0; n <= DEPTH; n++) begin
      lat = 1 + (n % 3); err_at = -1; log_n = 0;
      for (int i = 0; i < n; i++) push(2'd1, i, fdat(n, i));
      go();
      wait_done(res, cyc);
      chk(res == 0, "R7 sweep result ok", res, 0);
      chk(log_n == n, "R11 sweep write count", log_n, n);
      for (int i = 0; i < n; i++)
        chk(log_a[i] == AW'(i) && log_d[i] == DW'(fdat(n, i)), "R11 sweep order/data", int'(log_d[i]), fdat(n, i));
      @(negedge clk);
    end

    // Enable timing around one write (R4)
    lat = 3; log_n = 0;
    push(2'd1, 5, 16'h1234);
    go();
    @(negedge clk);
    chk(wr_en && wc_irq_en && status == 2, "R4 strobe with enable", {wr_en, wc_irq_en}, 3);
    @(negedge clk);
    chk(!wr_en && wc_irq_en, "R4 strobe single cycle", wr_en, 0);
    wait_done(res, cyc);
    chk(!wc_irq_en && res == 0, "R4 enable dropped", wc_irq_en, 0);
    @(negedge clk);

    // Write error at each position (R5)
    for (int k = 0; k < 4; k++) begin
      lat = 2; err_at = k; log_n = 0;
      for (int i = 0; i < 4; i++) push(2'd1, i + 8, i);
      go();
      wait_done(res, cyc);
      chk(res == 1, "R5 write error result", res, 1);
      chk(log_n == k + 1, "R5 writes stop at error", log_n, k + 1);
      chk(!wc_irq_en && !busy, "R5 enable cleared", wc_irq_en, 0);
      @(negedge clk);
    end
    err_at = -1;

    // Key waits: valid, error, both (R6)
    for (int m = 0; m < 3; m++) begin
      rk_mode = m; log_n = 0; lat = 1;
      push(2'd1, 1, 11); push(2'd2, 0, 0); push(2'd1, 2, 22);
      go();
      wait_done(res, cyc);
      chk(res == (m == 0 ? 0 : 2), "R6 key wait result", res, (m == 0 ? 0 : 2));
      chk(log_n == (m == 0 ? 2 : 1), "R6 writes after key wait", log_n, (m == 0 ? 2 : 1));
      chk(!rk_irq_en, "R6 key enable cleared", rk_irq_en, 0);
      @(negedge clk);
    end
    rk_mode = 0;

    // No-operation kinds 0 and 3 (R2)
    log_n = 0;
    push(2'd0, 3, 1); push(2'd1, 4, 44); push(2'd3, 5, 2); push(2'd1, 6, 66);
    go();
    wait_done(res, cyc);
    chk(res == 0 && log_n == 2, "R2 nop issues no write", log_n, 2);
    chk(log_a[0] == 4 && log_a[1] == 6, "R2 nop order", int'(log_a[1]), 6);
    @(negedge clk);

    // Stray flags and pushes during a key wait (R8, R6)
    rk_mute = 1; log_n = 0;
    push(2'd2, 0, 0);
    go();
    repeat (3) @(negedge clk);
    chk(status == 3 && rk_irq_en, "R6 key enable while waiting", status, 3);
    wc_x = 1; we_x = 1; push_valid = 1; push_kind = 2'd1; push_addr = 9; push_data = 99;
    @(negedge clk);
    wc_x = 0; we_x = 0; push_valid = 0;
    @(negedge clk);
    chk(status == 3 && busy && !done, "R8 stray write flags ignored", status, 3);
    rkv_x = 1;
    @(negedge clk);
    rkv_x = 0;
    wait_done(res, cyc);
    chk(res == 0 && log_n == 0, "R8 push during run ignored", log_n, 0);
    rk_mute = 0;
    @(negedge clk);

    // Overflow on thirteenth push (R1)
    lat = 1; log_n = 0;
    for (int i = 0; i < DEPTH; i++) push(2'd1, i, i + 100);
    chk(!overflow, "R1 no overflow at capacity", overflow, 0);
    push(2'd1, 15, 999);
    chk(overflow, "R1 overflow on full push", overflow, 1);
    go();
    wait_done(res, cyc);
    chk(log_n == DEPTH && log_a[DEPTH-1] == AW'(DEPTH - 1), "R1 extra entry dropped", log_n, DEPTH);
    @(negedge clk);
    chk(!overflow && status == 0, "R1 overflow cleared after done", overflow, 0);

    // Timeout (R10)
    wr_mute = 1; log_n = 0;
    push(2'd1, 7, 77);
    go();
    @(negedge clk);
    chk(wr_en == 1, "R10 write issued", wr_en, 1);
    repeat (TMO - 1) @(negedge clk);
    chk(!done && busy, "R10 still waiting before limit", done, 0);
    @(negedge clk);
    chk(done && result == 1, "R10 timeout write error", result, 1);
    wr_mute = 0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule